// File: doc/BRIEF.md
# Posted-Write Queue with Read-Miss Bypass

This block sits between a first-level cache and the next memory level. The cache hands it write requests, each an address and a data word. A write is taken in one cycle, so the processor does not wait for the next level. The queue then sends the pending writes downstream, one at a time and oldest first, over a valid/ready request port. This port is shared with read misses. In a write-through, no-allocate cache, every store is given to the queue, whether it hit or missed.

Reads that hit in the cache never reach this block. When a read misses, the cache presents the missing address. All pending entries are compared with it at once. If any entry matches, the data of the youngest matching write is returned in the same cycle and nothing goes downstream for that read. If nothing matches, the read takes the shared downstream port ahead of any pending drain. This means a read can never overtake an older write to the same address and return stale data.

Top module: `wbuf_fwd`

## Requirements
- R1: While the queue holds fewer than DEPTH entries, `wr_ready` is high and a write presented with `wr_valid` is captured at that clock edge, whatever the state of `nl_ready`.
- R2: While the queue holds DEPTH entries, `wr_ready` is low. A write presented then is discarded and never appears on the downstream port.
- R3: Whenever the queue is non-empty and no unmatched read miss is present, `nl_valid`=1 and `nl_write`=1, and `nl_addr`/`nl_data` carry the oldest entry. The entry leaves the queue on a cycle with `nl_ready`=1, so writes go downstream in arrival order.
- R4: A drain that is not accepted (`nl_ready`=0) presents the same address and data the next time `nl_write` is high.
- R5: A read miss (`rd_valid`=1) whose `rd_addr` equals the address of any pending entry gives `rd_hit`=1 and `rd_ready`=1 in that cycle, with `rd_data` taken from the queue. No read request goes downstream for it.
- R6: When several pending entries match the read address, `rd_data` is the data of the most recently accepted one.
- R7: A write accepted in the same cycle as a read miss to the same address takes part in the comparison and counts as the youngest match.
- R8: A read miss with no match drives `nl_valid`=1, `nl_write`=0 and `nl_addr`=`rd_addr`, taking the port ahead of any drain. `rd_ready` then equals `nl_ready`, and no queue entry leaves in that cycle.
- R9: After a synchronous reset the queue is empty: `wr_ready`=1, and `nl_valid`=0 while no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request from the cache |
| wr_ready | output | 1 | Queue has room; write taken at this edge |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read miss lookup request |
| rd_addr | input | ADDR_W | Read miss address |
| rd_ready | output | 1 | Read miss served from the queue or accepted downstream |
| rd_hit | output | 1 | Read miss satisfied from the queue |
| rd_data | output | DATA_W | Forwarded data, valid with `rd_hit` |
| nl_valid | output | 1 | Request to the next level |
| nl_ready | input | 1 | Next level accepts the request |
| nl_write | output | 1 | 1 = drained write, 0 = read miss |
| nl_addr | output | ADDR_W | Request address |
| nl_data | output | DATA_W | Write data for a drained entry |

## Verification
The assertions assume only two things about the inputs: every input is settled before each rising edge, and reset is held low for at least one edge. They do not assume that `rd_addr` is held until `rd_ready`. The properties are written for each cycle, so a read that changes from cycle to cycle is legal. The bench drives all inputs on the falling edge and compares outputs a quarter period later. Its addresses come from a set of four values, so that repeated and same-cycle matches occur often. It also drops `nl_ready` at random, so that drains stall and read misses take the port while writes are waiting.

// File: rtl/wbf_pkg.sv
// Package: shared types for the posted-write queue.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package wbf_pkg;
    // Owner of the shared downstream request port in a cycle.
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_READ  = 2'd1,
        PORT_DRAIN = 2'd2
    } port_sel_e;
endpackage

// File: rtl/wbf_ring.sv
// Module: circular store of pending writes, oldest at the head slot.
// Assumes DEPTH is a power of two, at least 2, so pointer wrap is free.
// The caller must not push while full or pop while empty.
module wbf_ring #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [ADDR_W-1:0]              push_addr,
    input  logic [DATA_W-1:0]              push_data,
    input  logic                           pop,
    output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]   slot_data,
    output logic [PTR_W-1:0]               head,
    output logic [CNT_W-1:0]               count,
    output logic                           full,
    output logic                           empty
);
    logic [PTR_W-1:0] tail;

    assign tail  = head + count[PTR_W-1:0];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // Capture an accepted write into the slot after the youngest entry.
    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tail] <= push_addr;
            slot_data[tail] <= push_data;
        end
    end

    // Advance the head pointer and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else begin
            if (pop) head <= head + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wbf_lookup.sv
// Module: parallel address compare over all pending entries plus the write
// being accepted this cycle; returns the youngest match.
// Assumes slots are ordered oldest-first starting at head, DEPTH power of two.
module wbf_lookup #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]   slot_data,
    input  logic [PTR_W-1:0]               head,
    input  logic [CNT_W-1:0]               count,
    input  logic                           inc_valid,
    input  logic [ADDR_W-1:0]              inc_addr,
    input  logic [DATA_W-1:0]              inc_data,
    input  logic [ADDR_W-1:0]              key,
    output logic                           hit,
    output logic [DATA_W-1:0]              data
);
    // Walk from oldest to youngest so the last match seen wins.
    always_comb begin : walk
        logic [PTR_W-1:0] s;
        hit  = 1'b0;
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            s = head + PTR_W'(i);
            if ((CNT_W'(i) < count) && (slot_addr[s] == key)) begin
                hit  = 1'b1;
                data = slot_data[s];
            end
        end
        if (inc_valid && (inc_addr == key)) begin
            hit  = 1'b1;
            data = inc_data;
        end
    end
endmodule

// File: rtl/wbuf_fwd.sv
// Module: posted-write queue with read-miss bypass (top).
// Writes are taken while not full and drained in order over a shared
// valid/ready port; an unmatched read miss owns that port first.
// Assumes DEPTH is a power of two and at least 2.
module wbuf_fwd
    import wbf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data,
    output logic              nl_valid,
    input  logic              nl_ready,
    output logic              nl_write,
    output logic [ADDR_W-1:0] nl_addr,
    output logic [DATA_W-1:0] nl_data
);
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;
    logic [PTR_W-1:0]             head;
    logic [CNT_W-1:0]             fill;
    logic                         full, empty;
    logic                         push, pop;
    logic                         lk_hit;
    logic [DATA_W-1:0]            lk_data;
    port_sel_e                    sel;

    assign push     = wr_valid & ~full;
    assign wr_ready = ~full;

    wbf_ring #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (pop),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .head      (head),
        .count     (fill),
        .full      (full),
        .empty     (empty)
    );

    wbf_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_lookup (
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .head      (head),
        .count     (fill),
        .inc_valid (push),
        .inc_addr  (wr_addr),
        .inc_data  (wr_data),
        .key       (rd_addr),
        .hit       (lk_hit),
        .data      (lk_data)
    );

    // Choose the downstream port owner: unmatched read, then drain.
    always_comb begin
        if (rd_valid && !lk_hit) sel = PORT_READ;
        else if (!empty)         sel = PORT_DRAIN;
        else                     sel = PORT_IDLE;
    end

    // Drive the downstream request fields from the chosen owner.
    always_comb begin
        nl_valid = (sel != PORT_IDLE);
        nl_write = (sel == PORT_DRAIN);
        nl_addr  = (sel == PORT_READ) ? rd_addr : slot_addr[head];
        nl_data  = slot_data[head];
    end

    assign pop      = (sel == PORT_DRAIN) & nl_ready;
    assign rd_hit   = rd_valid & lk_hit;
    assign rd_data  = lk_data;
    assign rd_ready = rd_valid & (lk_hit | nl_ready);
endmodule

// File: rtl/wbuf_fwd_chk.sv
// Module: property checker for wbuf_fwd, attached by bind.
// Assumes inputs settle before each rising edge and reset spans an edge.
module wbuf_fwd_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              rd_valid,
    input logic              rd_hit,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              nl_valid,
    input logic              nl_ready,
    input logic              nl_write,
    input logic [ADDR_W-1:0] nl_addr,
    input logic [DATA_W-1:0] nl_data,
    input logic [CNT_W-1:0]  fill
);
    p_room_accepts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fill < CNT_W'(DEPTH)) |-> wr_ready);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill >= CNT_W'(DEPTH)) |-> !wr_ready);

    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    p_pending_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != '0) |-> nl_valid);

    p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nl_valid && nl_write && !nl_ready) |=>
        (nl_valid && (!nl_write || ($stable(nl_addr) && $stable(nl_data)))));

    p_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> !(nl_valid && !nl_write));

    p_hit_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> ((fill != '0) || (wr_valid && wr_ready)));

    p_read_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_hit) |-> (nl_valid && !nl_write && nl_addr == rd_addr));

    p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!nl_valid && !rd_valid) |-> (fill == '0));
endmodule

bind wbuf_fwd wbuf_fwd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .rd_hit   (rd_hit),
    .rd_addr  (rd_addr),
    .nl_valid (nl_valid),
    .nl_ready (nl_ready),
    .nl_write (nl_write),
    .nl_addr  (nl_addr),
    .nl_data  (nl_data),
    .fill     (fill)
);

// File: tb/test_wbuf_fwd.sv
// Bench: behavioural queue model compared against wbuf_fwd every cycle.
module test_wbuf_fwd;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, rd_valid = 1'b0, nl_ready = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic wr_ready, rd_ready, rd_hit, nl_valid, nl_write;
    logic [DW-1:0] rd_data, nl_data;
    logic [AW-1:0] nl_addr;

    int checks = 0;
    int fails = 0;
    logic [AW-1:0] qa[$];
    logic [DW-1:0] qd[$];
    bit stalled_prev = 0;
    bit first_cycle = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbuf_fwd #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) i_wbuf_fwd (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_hit(rd_hit), .rd_data(rd_data),
        .nl_valid(nl_valid), .nl_ready(nl_ready), .nl_write(nl_write),
        .nl_addr(nl_addr), .nl_data(nl_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // One cycle: drive at falling edge, compare, then advance the model.
    task automatic cyc(input bit wv, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input bit rv, input logic [AW-1:0] ra, input bit nr);
        bit e_wr_ready, inc, hit, same, rd_go, e_nl_valid, e_nl_write;
        int nmatch;
        logic [DW-1:0] hd;
        logic [AW-1:0] e_nl_addr;
        @(negedge clk);
        wr_valid = wv; wr_addr = wa; wr_data = wd;
        rd_valid = rv; rd_addr = ra; nl_ready = nr;
        #(CLK_PERIOD/4);
        e_wr_ready = (qa.size() < DEPTH);
        inc = wv && e_wr_ready;
        hit = 0; same = 0; nmatch = 0; hd = '0;
        for (int j = 0; j < qa.size(); j++)
            if (qa[j] == ra) begin hit = 1; hd = qd[j]; nmatch++; end
        if (inc && wa == ra) begin hit = 1; hd = wd; same = 1; nmatch++; end
        rd_go = rv && !hit;
        e_nl_valid = rd_go || (qa.size() > 0);
        e_nl_write = !rd_go;
        e_nl_addr = rd_go ? ra : (qa.size() > 0 ? qa[0] : '0);
        chk(first_cycle ? "R9" : (e_wr_ready ? "R1" : "R2"), "wr_ready", wr_ready, e_wr_ready);
        chk(first_cycle ? "R9" : "R5", "rd_hit", rd_hit, rv && hit);
        if (rv && hit)
            chk(same ? "R7" : (nmatch > 1 ? "R6" : "R5"), "rd_data", rd_data, hd);
        chk(first_cycle ? "R9" : "R8", "rd_ready", rd_ready, rv && (hit || nr));
        chk(first_cycle ? "R9" : "R3", "nl_valid", nl_valid, e_nl_valid);
        if (e_nl_valid) begin
            chk("R8", "nl_write", nl_write, e_nl_write);
            chk(rd_go ? "R8" : (stalled_prev ? "R4" : "R3"), "nl_addr", nl_addr, e_nl_addr);
            if (e_nl_write)
                chk(stalled_prev ? "R4" : "R3", "nl_data", nl_data, qd[0]);
        end
        first_cycle = 0;
        @(posedge clk);
        if (e_nl_valid && e_nl_write) stalled_prev = !nr;
        if (e_nl_valid && e_nl_write && nr) begin
            void'(qa.pop_front()); void'(qd.pop_front());
        end
        if (inc) begin qa.push_back(wa); qd.push_back(wd); end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        first_cycle = 1;
        // R9: idle after reset
        cyc(0, 0, 0, 0, 0, 1);
        // R1/R2: fill with downstream stalled, then a refused write
        cyc(1, 'h10, 'hD1, 0, 0, 0);
        cyc(1, 'h20, 'hD2, 0, 0, 0);
        cyc(1, 'h10, 'hD3, 0, 0, 0);
        cyc(1, 'h30, 'hD4, 0, 0, 0);
        cyc(1, 'h40, 'hBAD, 0, 0, 0);
        // R6: youngest of two matches
        cyc(0, 0, 0, 1, 'h10, 0);
        // R8: miss takes port while drain waits, then accepted
        cyc(0, 0, 0, 1, 'h40, 0);
        cyc(0, 0, 0, 1, 'h40, 1);
        // R3/R2: drain order, refused write must not appear
        for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 1);
        // R7: same-cycle write overrides an older match
        cyc(1, 'h50, 'hD6, 0, 0, 0);
        cyc(1, 'h50, 'hD7, 1, 'h50, 0);
        // R4: stall, read steals port, drain resumes unchanged
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 'h70, 0);
        cyc(0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 1);
        // Mixed traffic over a small address set
        for (int k = 0; k < 4000; k++)
            cyc($urandom_range(0, 2) != 0, AW'($urandom_range(0, 3) * 4),
                DW'($urandom), $urandom_range(0, 2) == 0,
                AW'($urandom_range(0, 3) * 4), $urandom_range(0, 2) == 0);
        summary();
    end
endmodule